// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block turns a fast system clock into the SCL waveform and the SDA drive, change and sample events that an I2C master needs. A bit-level engine sits above it and asks for one bus action at a time: a START condition, a STOP condition, one written bit or one read bit. The block carries out each action with programmed durations and reports back with a one-cycle done pulse. A read result comes back with that pulse.

Every bus interval is a count of prescaler ticks. One tick is DIV+1 system clocks. The intervals are SCL low, SCL high, START setup, START hold, STOP setup, data setup, data hold and the repeated-START release time. They come from packed timing words. There are two complete sets of these words, one for fast mode and one for high-speed mode, and the data hold word is shared by both. A fixed overhead of 8 + K×FLT system clocks is added to every SCL low phase. FLT is a 3-bit filter count and K is a parameter that defaults to 2. SCL and SDA are open-drain: an output of 1 releases the line and 0 pulls it low. The block senses SCL back through `scl_i`, so a target that holds SCL low stretches the high phase.

Top module: `i2c_bit_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `scl_o` and `sda_o` are 1, `cmd_ready` is 1 and `cmd_done` is 0.
- R2: For a write or read bit, `scl_o` stays 0 for (E−1) + (LO+1)×(DIV+1) clocks, counted from the clock edge that accepts the command. E = 8 + K×FLT, where FLT is `flt_cyc` captured at acceptance and K = 2.
- R3: Without stretching, `scl_o` stays 1 for 1 + (HI+1)×(DIV+1) clocks. One full bit therefore takes (DIV+1)×(LO+HI+2) + 8 + K×FLT clocks. `cmd_done` pulses on the edge where `scl_o` falls again.
- R4: The high-phase count starts only after `scl_i` is seen high. If a target holds SCL low for S ≥ 1 cycles after release, `scl_o` stays 1 for S + (HI+1)×(DIV+1) clocks.
- R5: In a bit, `sda_o` takes the new value at the end of prescaler tick P+1 of the low count. A read bit uses the value 1. `sda_chg` pulses once on that edge, and `sda_o` does not move while `scl_o` is 1 during a bit.
- R6: P is the data hold count when LO ≥ HOLD + SETUP + 1. When that does not hold, setup wins: P = LO − SETUP − 1 if LO > SETUP, otherwise 0.
- R7: A read bit samples `sda_i` on the last clock of the high phase. It presents the value on `rx_bit` and pulses `sda_smp`, both together with `cmd_done`.
- R8: A START issued when the bus is free holds SDA and SCL released for (STA_SU+1)×(DIV+1) clocks. It then pulls SDA low for (STA_HD+1)×(DIV+1) clocks, pulls SCL low, and the bus is owned.
- R9: A START issued while the bus is owned is a repeated START. SDA is released at once with SCL low for (SR+1)×(DIV+1) clocks. SCL is then released and, once sensed high, the R8 setup and hold follow.
- R10: A STOP issued while owned pulls SDA low with SCL low for (HOLD+1)×(DIV+1) clocks. It then releases SCL, and once SCL is sensed high it waits (STO_SU+1)×(DIV+1) clocks and releases SDA. The bus is then free.
- R11: A STOP, write or read issued while the bus is free causes no bus activity. `cmd_done` pulses on the edge after acceptance and `scl_o` and `sda_o` stay 1.
- R12: `hs_mode` = 1 selects the high-speed words and 0 selects the fast words. The set, FLT and the hold word are captured when a command is accepted, and changing them during a command has no effect on it.
- R13: Field positions. Word 1: START setup [31:24], START hold [23:16], STOP setup [15:8]. Word 2: data setup [31:24], SCL low [15:8], SCL high [7:0]. Word 3: DIV [23:16], repeated-START release [7:0]. Hold word: data hold [7:0]. `cmd_op` encoding: 0 START, 1 STOP, 2 write, 3 read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1 selects the high-speed timing set |
| flt_cyc | input | 3 | Filter cycle count used in the SCL low overhead |
| fs_w1 | input | 32 | Fast set: START setup, START hold, STOP setup |
| fs_w2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_w3 | input | 32 | Fast set: DIV, repeated-START release |
| hs_w1 | input | 32 | High-speed set, word 1 layout |
| hs_w2 | input | 32 | High-speed set, word 2 layout |
| hs_w3 | input | 32 | High-speed set, word 3 layout |
| hold_w | input | 32 | Data hold count, shared by both sets |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (R13) |
| cmd_bit | input | 1 | Bit value for a write |
| cmd_ready | output | 1 | Ready to accept a command |
| cmd_done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last bit sampled by a read |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive, 1 releases the line |
| sda_o | output | 1 | SDA drive, 1 releases the line |
| sda_chg | output | 1 | Pulse when SDA is updated inside a bit |
| sda_smp | output | 1 | Pulse when a read bit is sampled |

## Verification
A wrong phase counter or prescaler state shows up as SCL low or high windows that are a whole tick too long or too short. Within a single bit, the bench sees it as a wrong count of samples with `scl_o` at 0 or 1. A misplaced SDA change point moves the first sample at which `sda_o` shows the new value, which is visible during the low phase of the same bit. Wrong ownership tracking shows as a START taken as the wrong kind, or a STOP that moves the lines when it should not, within one command.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  localparam int FW     = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef struct packed {
    logic [FW-1:0] sta_su;
    logic [FW-1:0] sta_hd;
    logic [FW-1:0] sto_su;
    logic [FW-1:0] dat_hd;
    logic [FW-1:0] scl_lo;
    logic [FW-1:0] scl_hi;
    logic [FW-1:0] div;
    logic [FW-1:0] sr_rel;
    logic [FW-1:0] sda_pt;
    logic [FW-1:0] ovh_last;
  } bt_cfg_t;
endpackage

// File: rtl/i2c_bt_cfg.sv
module i2c_bt_cfg
  import i2c_bt_pkg::*;
#(
  parameter int FLT_W    = 3,
  parameter int FLT_MULT = 2,
  parameter int FIX_OVH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              hs_mode,
  input  logic [FLT_W-1:0]  flt_cyc,
  input  logic [WORD_W-1:0] fs_w1,
  input  logic [WORD_W-1:0] fs_w2,
  input  logic [WORD_W-1:0] fs_w3,
  input  logic [WORD_W-1:0] hs_w1,
  input  logic [WORD_W-1:0] hs_w2,
  input  logic [WORD_W-1:0] hs_w3,
  input  logic [WORD_W-1:0] hold_w,
  output bt_cfg_t           cfg
);
  localparam int OVH_BASE = FIX_OVH - 2;

  logic [WORD_W-1:0] w1, w2, w3;
  logic [FW-1:0]     lo, su, hd;
  logic [FW:0]       need;
  logic [FW-1:0]     pt;
  bt_cfg_t           nxt;
  logic              unused_bits;

  assign w1 = hs_mode ? hs_w1 : fs_w1;
  assign w2 = hs_mode ? hs_w2 : fs_w2;
  assign w3 = hs_mode ? hs_w3 : fs_w3;
  assign lo = w2[15:8];
  assign su = w2[31:24];
  assign hd = hold_w[7:0];
  assign unused_bits = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8], hold_w[WORD_W-1:8]};

  // setup has priority over hold when both do not fit in the low count
  assign need = {1'b0, hd} + {1'b0, su} + (FW+1)'(1);
  always_comb begin
    if ({1'b0, lo} >= need)  pt = hd;
    else if (lo > su)        pt = lo - su - FW'(1);
    else                     pt = '0;
  end

  always_comb begin
    nxt          = '0;
    nxt.sta_su   = w1[31:24];
    nxt.sta_hd   = w1[23:16];
    nxt.sto_su   = w1[15:8];
    nxt.dat_hd   = hd;
    nxt.scl_lo   = lo;
    nxt.scl_hi   = w2[7:0];
    nxt.div      = w3[23:16];
    nxt.sr_rel   = w3[7:0];
    nxt.sda_pt   = pt;
    nxt.ovh_last = FW'(OVH_BASE) + FW'(FLT_MULT) * FW'(flt_cyc);
  end

  always_ff @(posedge clk) begin
    if (rst)       cfg <= '0;
    else if (load) cfg <= nxt;
  end

  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg));
endmodule

// File: rtl/i2c_bt_presc.sv
module i2c_bt_presc
  import i2c_bt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [FW-1:0] div,
  output logic          tick
);
  logic [FW-1:0] pre;

  assign tick = (pre == div);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) pre <= '0;
    else                        pre <= pre + FW'(1);
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && div != '0) |=> !tick);
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bt_cfg_t    cfg,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       restart,
  output logic       load,
  output logic       cmd_ready,
  output logic       cmd_done,
  output logic       rx_bit,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sda_chg,
  output logic       sda_smp
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_OVH, ST_LOW, ST_WAIT_HI, ST_HIGH,
    ST_RS_REL, ST_RS_WAIT, ST_STA_SU, ST_STA_HD,
    ST_P_LOW, ST_P_WAIT, ST_P_SU
  } st_e;

  st_e           state;
  logic [FW-1:0] cnt;
  logic [FW-1:0] ph_len;
  logic          ticked, leave;
  logic          owned, wbit, is_read;
  op_e           op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign load      = cmd_valid && cmd_ready;

  always_comb begin
    ticked = 1'b1;
    ph_len = '0;
    case (state)
      ST_LOW:    ph_len = cfg.scl_lo;
      ST_HIGH:   ph_len = cfg.scl_hi;
      ST_RS_REL: ph_len = cfg.sr_rel;
      ST_STA_SU: ph_len = cfg.sta_su;
      ST_STA_HD: ph_len = cfg.sta_hd;
      ST_P_LOW:  ph_len = cfg.dat_hd;
      ST_P_SU:   ph_len = cfg.sto_su;
      default:   ticked = 1'b0;
    endcase
  end

  assign leave   = (state == ST_OVH) ? (cnt == cfg.ovh_last)
                                     : (ticked && tick && cnt == ph_len);
  assign restart = !ticked || leave;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      owned    <= 1'b0;
      wbit     <= 1'b1;
      is_read  <= 1'b0;
      scl_o    <= 1'b1;
      sda_o    <= 1'b1;
      cmd_done <= 1'b0;
      rx_bit   <= 1'b0;
      sda_chg  <= 1'b0;
      sda_smp  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      sda_chg  <= 1'b0;
      sda_smp  <= 1'b0;

      if (leave)                              cnt <= '0;
      else if (state == ST_OVH)               cnt <= cnt + FW'(1);
      else if (ticked && tick)                cnt <= cnt + FW'(1);
      else if (!ticked)                       cnt <= '0;

      case (state)
        ST_IDLE: if (cmd_valid) begin
          case (op)
            OP_START: if (owned) begin
                state <= ST_RS_REL;
                sda_o <= 1'b1;
              end else state <= ST_STA_SU;
            OP_STOP: if (owned) begin
                state <= ST_P_LOW;
                sda_o <= 1'b0;
              end else cmd_done <= 1'b1;
            default: if (owned) begin
                state   <= ST_OVH;
                is_read <= (op == OP_READ);
                wbit    <= (op == OP_READ) ? 1'b1 : cmd_bit;
              end else cmd_done <= 1'b1;
          endcase
        end
        ST_OVH: if (leave) state <= ST_LOW;
        ST_LOW: begin
          if (tick && cnt == cfg.sda_pt) begin
            sda_o   <= wbit;
            sda_chg <= 1'b1;
          end
          if (leave) begin
            state <= ST_WAIT_HI;
            scl_o <= 1'b1;
          end
        end
        ST_WAIT_HI: if (scl_i) state <= ST_HIGH;
        ST_HIGH: if (leave) begin
          state    <= ST_IDLE;
          scl_o    <= 1'b0;
          cmd_done <= 1'b1;
          if (is_read) begin
            rx_bit  <= sda_i;
            sda_smp <= 1'b1;
          end
        end
        ST_RS_REL: if (leave) begin
          state <= ST_RS_WAIT;
          scl_o <= 1'b1;
        end
        ST_RS_WAIT: if (scl_i) state <= ST_STA_SU;
        ST_STA_SU: if (leave) begin
          state <= ST_STA_HD;
          sda_o <= 1'b0;
        end
        ST_STA_HD: if (leave) begin
          state    <= ST_IDLE;
          scl_o    <= 1'b0;
          owned    <= 1'b1;
          cmd_done <= 1'b1;
        end
        ST_P_LOW: if (leave) begin
          state <= ST_P_WAIT;
          scl_o <= 1'b1;
        end
        ST_P_WAIT: if (scl_i) state <= ST_P_SU;
        ST_P_SU: if (leave) begin
          state    <= ST_IDLE;
          sda_o    <= 1'b1;
          owned    <= 1'b0;
          cmd_done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_low_scl_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OVH || state == ST_LOW) |-> !scl_o);
  p_high_sensed_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH && $past(state) == ST_WAIT_HI) |-> $past(scl_i));
  p_sda_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (scl_o && (state == ST_WAIT_HI || state == ST_HIGH)) |=> $stable(sda_o));
  p_chg_low_r5: assert property (@(posedge clk) disable iff (rst)
    sda_chg |-> !scl_o);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> cmd_ready);
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int FLT_W    = 3,
  parameter int FLT_MULT = 2,
  parameter int FIX_OVH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_mode,
  input  logic [FLT_W-1:0]  flt_cyc,
  input  logic [WORD_W-1:0] fs_w1,
  input  logic [WORD_W-1:0] fs_w2,
  input  logic [WORD_W-1:0] fs_w3,
  input  logic [WORD_W-1:0] hs_w1,
  input  logic [WORD_W-1:0] hs_w2,
  input  logic [WORD_W-1:0] hs_w3,
  input  logic [WORD_W-1:0] hold_w,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bit,
  output logic              cmd_ready,
  output logic              cmd_done,
  output logic              rx_bit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_chg,
  output logic              sda_smp
);
  bt_cfg_t cfg;
  logic    load, restart, tick;

  i2c_bt_cfg #(.FLT_W(FLT_W), .FLT_MULT(FLT_MULT), .FIX_OVH(FIX_OVH)) u_cfg (
    .clk(clk), .rst(rst), .load(load), .hs_mode(hs_mode), .flt_cyc(flt_cyc),
    .fs_w1(fs_w1), .fs_w2(fs_w2), .fs_w3(fs_w3),
    .hs_w1(hs_w1), .hs_w2(hs_w2), .hs_w3(hs_w3),
    .hold_w(hold_w), .cfg(cfg)
  );

  i2c_bt_presc u_presc (
    .clk(clk), .rst(rst), .restart(restart), .div(cfg.div), .tick(tick)
  );

  i2c_bt_seq u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .scl_i(scl_i), .sda_i(sda_i), .restart(restart), .load(load),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .rx_bit(rx_bit),
    .scl_o(scl_o), .sda_o(sda_o), .sda_chg(sda_chg), .sda_smp(sda_smp)
  );
endmodule

// File: tb/sim_i2c_bit_timer.sv
module sim_i2c_bit_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hs_mode = 1'b0;
  logic [2:0]  flt_cyc = 3'd0;
  logic [31:0] fs_w1, fs_w2, fs_w3, hs_w1, hs_w2, hs_w3, hold_w;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_bit = 1'b0;
  logic        cmd_ready, cmd_done, rx_bit, scl_o, sda_o, sda_chg, sda_smp;
  logic        stretch = 1'b0;
  logic        slv_sda = 1'b1;
  logic        scl_i, sda_i;

  int total = 0;
  int bad = 0;
  int n_l, n_h1, n_h0, idx, n_chg, n_smp, k;

  assign scl_i = scl_o & ~stretch;
  assign sda_i = sda_o & slv_sda;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bit_timer u0 (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .flt_cyc(flt_cyc),
    .fs_w1(fs_w1), .fs_w2(fs_w2), .fs_w3(fs_w3),
    .hs_w1(hs_w1), .hs_w2(hs_w2), .hs_w3(hs_w3), .hold_w(hold_w),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .rx_bit(rx_bit),
    .scl_i(scl_i), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .sda_chg(sda_chg), .sda_smp(sda_smp)
  );

  function automatic logic [31:0] mk1(int su, int hd, int sto);
    return {8'(su), 8'(hd), 8'(sto), 8'h00};
  endfunction
  function automatic logic [31:0] mk2(int dsu, int lo, int hi);
    return {8'(dsu), 8'h00, 8'(lo), 8'(hi)};
  endfunction
  function automatic logic [31:0] mk3(int dv, int sr);
    return {8'h00, 8'(dv), 8'h00, 8'(sr)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // issues one command at a negedge and profiles the lines until done
  task automatic issue(logic [1:0] op, logic b, int s_n, logic flip);
    logic prev;
    while (!cmd_ready) @(negedge clk);
    prev = sda_o;
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1; stretch = (s_n > 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (flip) hs_mode = ~hs_mode;
    n_l = 0; n_h1 = 0; n_h0 = 0; idx = 0; n_chg = 0; n_smp = 0; k = 0;
    while (!cmd_done && k < 5000) begin
      k++;
      if (scl_o) begin
        if (sda_o) n_h1++; else n_h0++;
        if (stretch && (n_h1 + n_h0) >= s_n) stretch = 1'b0;
      end else n_l++;
      if (idx == 0 && sda_o != prev) idx = k;
      if (sda_chg) n_chg++;
      if (sda_smp) n_smp++;
      @(negedge clk);
    end
    if (sda_smp) n_smp++;
    stretch = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "scl_o", int'(scl_o), 1);
    check("R1", "sda_o", int'(sda_o), 1);
    check("R1", "cmd_ready", int'(cmd_ready), 1);
    check("R1", "cmd_done", int'(cmd_done), 0);
  endtask

  task automatic t_free_bus;
    issue(2'd1, 1'b0, 0, 1'b0);
    check("R11", "stop free cycles", k, 0);
    check("R11", "stop free scl", int'(scl_o), 1);
    issue(2'd2, 1'b0, 0, 1'b0);
    check("R11", "write free cycles", k, 0);
    check("R11", "write free sda", int'(sda_o), 1);
  endtask

  task automatic t_start;
    issue(2'd0, 1'b0, 0, 1'b0);
    check("R8", "setup clocks", n_h1, 12);
    check("R8", "hold clocks", n_h0, 10);
    check("R8", "scl after", int'(scl_o), 0);
    check("R13", "low during start", n_l, 0);
  endtask

  task automatic t_write1;
    issue(2'd2, 1'b1, 0, 1'b0);
    check("R2", "low clocks", n_l, 27);
    check("R3", "high clocks", n_h1 + n_h0, 17);
    check("R3", "period", n_l + n_h1 + n_h0, 2 * 18 + 8);
    check("R5", "sda change idx", idx, 14);
    check("R5", "chg strobes", n_chg, 1);
  endtask

  task automatic t_write0_flt;
    flt_cyc = 3'd3;
    issue(2'd2, 1'b0, 0, 1'b0);
    flt_cyc = 3'd0;
    check("R2", "low clocks flt3", n_l, 33);
    check("R5", "sda change idx flt3", idx, 20);
  endtask

  task automatic t_reads;
    slv_sda = 1'b0;
    issue(2'd3, 1'b0, 0, 1'b0);
    check("R7", "rx 0", int'(rx_bit), 0);
    check("R7", "smp strobe", n_smp, 1);
    slv_sda = 1'b1;
    issue(2'd3, 1'b0, 0, 1'b0);
    check("R7", "rx 1", int'(rx_bit), 1);
  endtask

  task automatic t_stretch;
    issue(2'd2, 1'b1, 5, 1'b0);
    check("R4", "stretched high", n_h1 + n_h0, 21);
    check("R4", "low unchanged", n_l, 27);
  endtask

  task automatic t_clamp;
    fs_w2 = mk2(4, 9, 7); hold_w = 32'd6;
    issue(2'd2, 1'b0, 0, 1'b0);
    check("R6", "setup-priority idx", idx, 18);
    fs_w2 = mk2(3, 9, 7); hold_w = 32'd2;
  endtask

  task automatic t_restart;
    issue(2'd0, 1'b0, 0, 1'b0);
    check("R9", "release low", n_l, 8);
    check("R9", "setup high", n_h1, 13);
    check("R9", "hold high", n_h0, 10);
  endtask

  task automatic t_hs;
    hs_mode = 1'b1;
    issue(2'd2, 1'b1, 0, 1'b0);
    check("R12", "hs low", n_l, 12);
    check("R12", "hs high", n_h1 + n_h0, 5);
    check("R12", "hs sda idx", idx, 11);
    hs_mode = 1'b0;
    issue(2'd2, 1'b0, 0, 1'b1);
    check("R12", "flip low", n_l, 27);
    check("R12", "flip high", n_h1 + n_h0, 17);
    hs_mode = 1'b0;
  endtask

  task automatic t_stop;
    issue(2'd1, 1'b0, 0, 1'b0);
    check("R10", "stop low", n_l, 6);
    check("R10", "stop setup", n_h0, 15);
    check("R10", "stop sda-high", n_h1, 0);
    check("R10", "sda after", int'(sda_o), 1);
    check("R10", "scl after", int'(scl_o), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fs_w1 = mk1(5, 4, 6); fs_w2 = mk2(3, 9, 7); fs_w3 = mk3(1, 3);
    hs_w1 = mk1(2, 2, 2); hs_w2 = mk2(1, 4, 3); hs_w3 = mk3(0, 1);
    hold_w = 32'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_free_bus();
    t_start();
    t_write1();
    t_write0_flt();
    t_reads();
    t_stretch();
    t_clamp();
    t_restart();
    t_hs();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule